// File: doc/BRIEF.md
# Eight-Source Two-Level Interrupt Controller

This block gathers eight interrupt requests and presents one of them at a time to a processor core. Four requests come from active-low external pins: a legacy pair and an added pair, and the added pair may share their pins with general-purpose port bits. Two come from timer overflow pulses. The last two are request levels held by a third timer and by the serial port. Each external input can be set to falling-edge or low-level sensing. Edge events and timer overflows are latched in pending flags, and those flags clear themselves when the core takes the interrupt.

Every source has an enable bit and a priority bit, and one global enable gates all of them. Inside a priority level a fixed polling order breaks ties. A high-priority request may interrupt a low-priority handler that is running. Nothing interrupts a high-priority handler. The core drives `ack` when it takes the presented vector and `reti` when it returns from a handler. Software reaches the control state through a byte register port. The register for the added external pair can also be written one bit at a time.

Top module: `irq8_ctrl`

## Requirements
- R1: After reset every control register reads 00h, `irq` is low and no level is in service.
- R2: When IT=1, a falling edge on an added external pin sets its pending flag. The flag is bit 1 of register C0h for external 2 and bit 5 for external 3. It is readable two clock edges after the pin falls, and `irq` follows one edge later. The flag stays set while the pin stays low, and it is cleared when the interrupt is acknowledged.
- R3: When IT=0, the external request follows the inverted pin and is not latched. It reads as the same flag bit one edge after the pin moves. `irq` rises one edge after that, and it falls two edges after the pin returns high.
- R4: Register C0h holds, from bit 7 down to bit 0: PX3, EX3, IE3, IT3, PX2, EX2, IE2, IT2. It can be written as a byte. A bit write to bit address C0h+n with n from 0 to 7 sets or clears bit n alone.
- R5: A source can request only when its enable bit is set and the global enable is also set. The global enable is bit 7 of register A8h. Bits 0 to 5 of A8h enable sources 0 to 5. EX2 and EX3 enable sources 6 and 7. A masked source keeps its pending flag set.
- R6: The source index runs 0 to 7 in this order: external 0, timer 0, external 1, timer 1, serial, timer 2, external 2, external 3. Within one level the lowest index wins. The vector is 03h + 8 × index.
- R7: Any pending high-priority source beats every low-priority source, whatever their indexes. Priority bits are bits 0 to 5 of register B8h for sources 0 to 5, and PX2 and PX3 for sources 6 and 7. `irq_hp` shows the level of the request being presented.
- R8: A high-priority request is presented while only a low-priority handler is in service. No request is presented while a high-priority handler is in service. A low-priority request waits while a low-priority handler is in service.
- R9: Each `reti` leaves one level. If a high-priority handler is in service, it ends that level first; otherwise it ends the low-priority level.
- R10: An acknowledge clears the latched flag of the source it takes. That applies to an external input in edge mode and to the timer 0 and timer 1 flags. The serial and timer 2 requests are levels owned by their peripherals and stay until those peripherals drop them.
- R11: `irq` is low at the clock edge after an `ack` is taken. An `ack` given while `irq` is low changes no flag and no in-service state.
- R12: Register 88h holds bit 0 IT0, bit 1 IE0, bit 2 IT1, bit 3 IE1, bit 4 TF0 and bit 5 TF1. External inputs 0 and 1 follow the same edge and level rules as the added pair. A one-cycle overflow pulse sets TF0 or TF1 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge is one sampling cycle |
| rst | input | 1 | Synchronous reset, active high |
| ext0_n | input | 1 | Legacy external request 0, active low |
| ext1_n | input | 1 | Legacy external request 1, active low |
| ext2_n | input | 1 | Added external request 2, active low |
| ext3_n | input | 1 | Added external request 3, active low |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tmr2_req | input | 1 | Timer 2 request level |
| ser_req | input | 1 | Serial port request level |
| wr_en | input | 1 | Byte register write strobe |
| reg_addr | input | RA_W | Register address for reads and byte writes |
| wr_data | input | REG_W | Byte write data |
| rd_data | output | REG_W | Read data of the register at reg_addr |
| bit_we | input | 1 | Single-bit write strobe for register C0h |
| bit_addr | input | RA_W | Bit address, C0h to C7h |
| bit_val | input | 1 | Value of the bit to write |
| ack | input | 1 | Core takes the presented vector |
| reti | input | 1 | Core returns from a handler |
| irq | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Vector address, valid while irq is high |
| irq_hp | output | 1 | Presented request is high priority |

## Verification
An edge-mode external flag shows in its register two edges after the pin falls, and `irq` with its vector follows one edge later. A level-mode request reads one edge after the pin moves and drives `irq` one edge after that. A timer pulse raises `irq` two edges after it is applied, and a register write shows on `irq` one edge after it lands. An acknowledge drops `irq` at the edge that takes it. Every check samples on the falling clock edge exactly that many rising edges after the stimulus. The arbitration sweep waits out the write sequence before it samples, then checks the result against a priority encoder that the bench works out arithmetically.

// File: rtl/irq8_pkg.sv
package irq8_pkg;

    localparam int NSRC  = 8;
    localparam int IDX_W = $clog2(NSRC);

    // Polling position of each source; a lower value wins inside a level.
    typedef enum logic [IDX_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4,
        SRC_TMR2 = 3'd5,
        SRC_EXT2 = 3'd6,
        SRC_EXT3 = 3'd7
    } src_e;

    // Stored configuration of one nibble of the added-external register.
    typedef struct packed {
        logic pri;
        logic en;
        logic edge_md;
    } xcfg_t;

    // Arbitration result.
    typedef struct packed {
        logic             valid;
        logic             hp;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic logic [IDX_W-1:0] lowest_set(input logic [NSRC-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq8_ext_sense.sv
module irq8_ext_sense (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic sw_we,
    input  logic sw_val,
    input  logic ack_clr,
    output logic req
);
    logic s0_q;
    logic s1_q;
    logic flag_q;
    logic fall;

    // High on the older sample, low on the newer one.
    assign fall = s1_q & ~s0_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s0_q   <= 1'b1;
            s1_q   <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            s0_q <= pin_n;
            s1_q <= s0_q;
            if (edge_mode && fall)
                flag_q <= 1'b1;
            else if (sw_we)
                flag_q <= sw_val;
            else if (ack_clr || !edge_mode)
                flag_q <= 1'b0;
        end
    end

    assign req = edge_mode ? flag_q : ~s0_q;

    // R2: a latched flag appears only from a detected edge or a software write.
    p_flag_origin_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(sw_we || (edge_mode && fall)));

endmodule

// File: rtl/irq8_arbiter.sv
module irq8_arbiter
    import irq8_pkg::*;
(
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] hi,
    input  logic            busy_lp,
    input  logic            busy_hp,
    output pick_t           pick
);
    logic [NSRC-1:0] hp_set;
    logic [NSRC-1:0] lp_set;

    assign hp_set = req & hi;
    assign lp_set = req & ~hi;

    always_comb begin
        pick = '0;
        if (!busy_hp) begin
            if (|hp_set) begin
                pick.valid = 1'b1;
                pick.hp    = 1'b1;
                pick.idx   = lowest_set(hp_set);
            end else if (!busy_lp && |lp_set) begin
                pick.valid = 1'b1;
                pick.hp    = 1'b0;
                pick.idx   = lowest_set(lp_set);
            end
        end
    end

endmodule

// File: rtl/irq8_inservice.sv
module irq8_inservice (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic push_hp,
    input  logic pop,
    output logic busy_lp,
    output logic busy_hp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_lp <= 1'b0;
            busy_hp <= 1'b0;
        end else if (push) begin
            if (push_hp) busy_hp <= 1'b1;
            else         busy_lp <= 1'b1;
        end else if (pop) begin
            if (busy_hp) busy_hp <= 1'b0;
            else         busy_lp <= 1'b0;
        end
    end

    // R8: the high level is entered only by taking a high-priority request.
    p_hp_entry_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_hp) |-> $past(push && push_hp));

    // R9: a return while high is active leaves the low level untouched.
    p_pop_order_r9: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && busy_hp) |=> (!busy_hp && busy_lp == $past(busy_lp)));

endmodule

// File: rtl/irq8_ctrl.sv
module irq8_ctrl
    import irq8_pkg::*;
#(
    parameter int          RA_W      = 8,
    parameter int          REG_W     = 8,
    parameter int          VEC_W     = 16,
    parameter int          VEC_BASE  = 3,
    parameter int          VEC_STEP  = 8,
    parameter logic [7:0]  ADDR_LEG  = 8'h88,
    parameter logic [7:0]  ADDR_EN   = 8'hA8,
    parameter logic [7:0]  ADDR_PRI  = 8'hB8,
    parameter logic [7:0]  ADDR_XCTL = 8'hC0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext0_n,
    input  logic             ext1_n,
    input  logic             ext2_n,
    input  logic             ext3_n,
    input  logic             tmr0_ovf,
    input  logic             tmr1_ovf,
    input  logic             tmr2_req,
    input  logic             ser_req,
    input  logic             wr_en,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             bit_we,
    input  logic [RA_W-1:0]  bit_addr,
    input  logic             bit_val,
    input  logic             ack,
    input  logic             reti,
    output logic             irq,
    output logic [VEC_W-1:0] irq_vec,
    output logic             irq_hp
);
    localparam int              NEXT     = 4;
    localparam int              NXC      = 2;
    localparam int              BPOS_W   = $clog2(REG_W);
    localparam logic [REG_W-1:0] EN_MASK = REG_W'(8'hBF);
    localparam int              GLB_BIT  = REG_W - 1;

    // ---------------- register writes ----------------
    logic wr_leg, wr_en_reg, wr_pri, wr_xctl, bit_hit;
    logic [BPOS_W-1:0] bpos;
    logic [REG_W-1:0]  xmask, xval;

    assign wr_leg    = wr_en && (reg_addr == RA_W'(ADDR_LEG));
    assign wr_en_reg = wr_en && (reg_addr == RA_W'(ADDR_EN));
    assign wr_pri    = wr_en && (reg_addr == RA_W'(ADDR_PRI));
    assign wr_xctl   = wr_en && (reg_addr == RA_W'(ADDR_XCTL));
    assign bit_hit   = bit_we && (bit_addr[RA_W-1:BPOS_W] == ADDR_XCTL[RA_W-1:BPOS_W]);
    assign bpos      = bit_addr[BPOS_W-1:0];

    // Byte write covers the whole register; bit write covers one position.
    always_comb begin
        xmask = '0;
        xval  = wr_data;
        if (wr_xctl) begin
            xmask = '1;
        end else if (bit_hit) begin
            xmask[bpos] = 1'b1;
            xval        = {REG_W{bit_val}};
        end
    end

    logic [REG_W-1:0] en_q;
    logic [5:0]       pri_q;
    logic             it0_q, it1_q, tf0_q, tf1_q;
    xcfg_t            xc_q [NXC];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            pri_q <= '0;
            it0_q <= 1'b0;
            it1_q <= 1'b0;
        end else begin
            if (wr_en_reg) en_q  <= wr_data & EN_MASK;
            if (wr_pri)    pri_q <= wr_data[5:0];
            if (wr_leg) begin
                it0_q <= wr_data[0];
                it1_q <= wr_data[2];
            end
        end
    end

    generate
        for (genvar g = 0; g < NXC; g++) begin : g_xcfg
            always_ff @(posedge clk) begin
                if (rst) begin
                    xc_q[g] <= '0;
                end else begin
                    if (xmask[4*g+0]) xc_q[g].edge_md <= xval[4*g+0];
                    if (xmask[4*g+2]) xc_q[g].en      <= xval[4*g+2];
                    if (xmask[4*g+3]) xc_q[g].pri     <= xval[4*g+3];
                end
            end
        end
    endgenerate

    // ---------------- acknowledge ----------------
    logic             irq_q, hp_q, take;
    logic [IDX_W-1:0] sel_q;
    logic             busy_lp, busy_hp;
    pick_t            pick;

    assign take = ack && irq_q;

    function automatic logic took(input logic t, input logic [IDX_W-1:0] s, input src_e src);
        return t && (s == src);
    endfunction

    // ---------------- timer flags ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            tf0_q <= 1'b0;
            tf1_q <= 1'b0;
        end else begin
            if (tmr0_ovf)                      tf0_q <= 1'b1;
            else if (wr_leg)                   tf0_q <= wr_data[4];
            else if (took(take, sel_q, SRC_TMR0)) tf0_q <= 1'b0;

            if (tmr1_ovf)                      tf1_q <= 1'b1;
            else if (wr_leg)                   tf1_q <= wr_data[5];
            else if (took(take, sel_q, SRC_TMR1)) tf1_q <= 1'b0;
        end
    end

    // ---------------- external inputs ----------------
    logic [NEXT-1:0] ext_pin, ext_edge, ext_swe, ext_swv, ext_clr, ext_req;

    assign ext_pin  = {ext3_n, ext2_n, ext1_n, ext0_n};
    assign ext_edge = {xc_q[1].edge_md, xc_q[0].edge_md, it1_q, it0_q};
    assign ext_swe  = {xmask[5], xmask[1], wr_leg, wr_leg};
    assign ext_swv  = {xval[5], xval[1], wr_data[3], wr_data[1]};
    assign ext_clr  = {took(take, sel_q, SRC_EXT3), took(take, sel_q, SRC_EXT2),
                       took(take, sel_q, SRC_EXT1), took(take, sel_q, SRC_EXT0)};

    generate
        for (genvar e = 0; e < NEXT; e++) begin : g_ext
            irq8_ext_sense u_sense (
                .clk       (clk),
                .rst       (rst),
                .pin_n     (ext_pin[e]),
                .edge_mode (ext_edge[e]),
                .sw_we     (ext_swe[e]),
                .sw_val    (ext_swv[e]),
                .ack_clr   (ext_clr[e]),
                .req       (ext_req[e])
            );
        end
    endgenerate

    // ---------------- request vector in polling order ----------------
    logic [NSRC-1:0] req_raw, en_vec, hi_vec, pend;

    assign req_raw = {ext_req[3], ext_req[2], tmr2_req, ser_req,
                      tf1_q, ext_req[1], tf0_q, ext_req[0]};
    assign en_vec  = {xc_q[1].en, xc_q[0].en, en_q[5:0]} & {NSRC{en_q[GLB_BIT]}};
    assign hi_vec  = {xc_q[1].pri, xc_q[0].pri, pri_q};
    assign pend    = req_raw & en_vec;

    irq8_arbiter u_arb (
        .req     (pend),
        .hi      (hi_vec),
        .busy_lp (busy_lp),
        .busy_hp (busy_hp),
        .pick    (pick)
    );

    irq8_inservice u_isr (
        .clk     (clk),
        .rst     (rst),
        .push    (take),
        .push_hp (hp_q),
        .pop     (reti),
        .busy_lp (busy_lp),
        .busy_hp (busy_hp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            hp_q  <= 1'b0;
            sel_q <= '0;
        end else begin
            irq_q <= pick.valid && !take;
            hp_q  <= pick.hp;
            sel_q <= pick.idx;
        end
    end

    assign irq     = irq_q;
    assign irq_hp  = irq_q && hp_q;
    assign irq_vec = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(sel_q);

    // ---------------- read port ----------------
    always_comb begin
        rd_data = '0;
        if (reg_addr == RA_W'(ADDR_LEG))
            rd_data = REG_W'({tf1_q, tf0_q, ext_req[1], it1_q, ext_req[0], it0_q});
        else if (reg_addr == RA_W'(ADDR_EN))
            rd_data = en_q;
        else if (reg_addr == RA_W'(ADDR_PRI))
            rd_data = REG_W'(pri_q);
        else if (reg_addr == RA_W'(ADDR_XCTL))
            rd_data = {xc_q[1].pri, xc_q[1].en, ext_req[3], xc_q[1].edge_md,
                       xc_q[0].pri, xc_q[0].en, ext_req[2], xc_q[0].edge_md};
    end

    // R11: a taken request is withdrawn at the next edge.
    p_ack_drop_r11: assert property (@(posedge clk) disable iff (rst)
        (ack && irq) |=> !irq);

    // R8: nothing is presented while the high level is in service.
    p_hp_block_r8: assert property (@(posedge clk) disable iff (rst)
        busy_hp |-> !irq);

    // R5: a request is presented only if the global enable was on.
    p_global_gate_r5: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(en_q[GLB_BIT]));

    // R7: a low-priority request is presented only when no high one was pending.
    p_hp_first_r7: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_hp) |-> $past((pend & hi_vec) == '0));

endmodule

// File: tb/irq8_ctrl_tb.sv
module irq8_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext0_n = 1'b1, ext1_n = 1'b1, ext2_n = 1'b1, ext3_n = 1'b1;
    logic        tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, tmr2_req = 1'b0, ser_req = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic        bit_we = 1'b0;
    logic [7:0]  bit_addr = 8'h00;
    logic        bit_val = 1'b0;
    logic        ack = 1'b0, reti = 1'b0;
    logic        irq;
    logic [15:0] irq_vec;
    logic        irq_hp;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    irq8_ctrl dut_i (
        .clk(clk), .rst(rst),
        .ext0_n(ext0_n), .ext1_n(ext1_n), .ext2_n(ext2_n), .ext3_n(ext3_n),
        .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .tmr2_req(tmr2_req), .ser_req(ser_req),
        .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
        .bit_we(bit_we), .bit_addr(bit_addr), .bit_val(bit_val),
        .ack(ack), .reti(reti),
        .irq(irq), .irq_vec(irq_vec), .irq_hp(irq_hp)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bw(input logic [7:0] a, input logic v);
        @(negedge clk);
        bit_we = 1'b1; bit_addr = a; bit_val = v;
        @(negedge clk);
        bit_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic pulse_reti();
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0;
    endtask

    function automatic int low_idx(input logic [7:0] v);
        int r = 0;
        for (int i = 7; i >= 0; i--) if (v[i]) r = i;
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] pri_sets [4];
        pri_sets[0] = 8'h00; pri_sets[1] = 8'hFF; pri_sets[2] = 8'hA5; pri_sets[3] = 8'h5A;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        rd(8'h88, d); check("R1 leg reg", 16'(d), 16'h00);
        rd(8'hA8, d); check("R1 en reg", 16'(d), 16'h00);
        rd(8'hB8, d); check("R1 pri reg", 16'(d), 16'h00);
        rd(8'hC0, d); check("R1 xctl reg", 16'(d), 16'h00);
        check("R1 irq low", 16'(irq), 16'h0);

        // R4 byte and bit access
        wr(8'hC0, 8'h99);
        rd(8'hC0, d); check("R4 byte write", 16'(d), 16'h99);
        bw(8'hC6, 1'b1);
        rd(8'hC0, d); check("R4 bit6 set", 16'(d), 16'hD9);
        bw(8'hC0, 1'b0);
        rd(8'hC0, d); check("R4 bit0 clear", 16'(d), 16'hD8);
        bw(8'hC6, 1'b0);
        rd(8'hC0, d); check("R4 bit6 clear", 16'(d), 16'h98);
        wr(8'hC0, 8'h00);

        // R2 edge mode on external 2
        wr(8'hA8, 8'h80);
        wr(8'hC0, 8'h05);
        ext2_n = 1'b0;
        tick(1);
        rd(8'hC0, d); check("R2 flag not yet", 16'(d), 16'h05);
        tick(1);
        rd(8'hC0, d); check("R2 flag set", 16'(d), 16'h07);
        check("R2 irq not yet", 16'(irq), 16'h0);
        tick(1);
        check("R2 irq", 16'(irq), 16'h1);
        check("R2 vector", irq_vec, 16'h0033);
        tick(3);
        rd(8'hC0, d); check("R2 flag held", 16'(d), 16'h07);
        pulse_ack();
        check("R11 irq drop", 16'(irq), 16'h0);
        rd(8'hC0, d); check("R2 R10 flag cleared by ack", 16'(d), 16'h05);
        pulse_reti();
        ext2_n = 1'b1;
        tick(2);

        // R3 level mode on external 3
        wr(8'hC0, 8'h40);
        ext3_n = 1'b0;
        tick(1);
        rd(8'hC0, d); check("R3 level reads", 16'(d), 16'h60);
        check("R3 irq not yet", 16'(irq), 16'h0);
        tick(1);
        check("R3 irq", 16'(irq), 16'h1);
        check("R3 vector", irq_vec, 16'h003B);
        ext3_n = 1'b1;
        tick(2);
        check("R3 irq drops", 16'(irq), 16'h0);
        rd(8'hC0, d); check("R3 not latched", 16'(d), 16'h40);

        // R5 masking keeps the flag
        wr(8'hA8, 8'h00);
        wr(8'hC0, 8'h07);
        tick(3);
        check("R5 global off", 16'(irq), 16'h0);
        rd(8'hC0, d); check("R5 flag kept", 16'(d), 16'h07);
        wr(8'hA8, 8'h80);
        tick(1);
        check("R5 global on", 16'(irq), 16'h1);
        check("R5 vector", irq_vec, 16'h0033);
        wr(8'hC0, 8'h03);
        tick(1);
        check("R5 source off", 16'(irq), 16'h0);
        rd(8'hC0, d); check("R5 flag kept masked", 16'(d), 16'h03);
        wr(8'hC0, 8'h00);

        // R12 legacy external 0 in edge mode
        wr(8'hA8, 8'h81);
        wr(8'h88, 8'h01);
        ext0_n = 1'b0;
        tick(2);
        rd(8'h88, d); check("R12 IE0 set", 16'(d), 16'h03);
        tick(1);
        check("R12 vector", irq_vec, 16'h0003);
        check("R12 irq", 16'(irq), 16'h1);
        pulse_ack();
        rd(8'h88, d); check("R10 IE0 cleared", 16'(d), 16'h01);
        pulse_reti();
        ext0_n = 1'b1;

        // R11 ack ignored while irq low; R12 timer pulse
        wr(8'hA8, 8'h00);
        @(negedge clk); tmr1_ovf = 1'b1;
        @(negedge clk); tmr1_ovf = 1'b0;
        rd(8'h88, d); check("R12 TF1 set", 16'(d), 16'h21);
        pulse_ack();
        rd(8'h88, d); check("R11 stray ack", 16'(d), 16'h21);
        wr(8'hA8, 8'h88);
        tick(1);
        check("R11 irq after stray ack", 16'(irq), 16'h1);
        check("R11 vector", irq_vec, 16'h001B);
        pulse_ack();
        rd(8'h88, d); check("R10 TF1 cleared", 16'(d), 16'h01);
        pulse_reti();
        wr(8'h88, 8'h00);

        // R8 R9 R10 nesting
        wr(8'hA8, 8'hBF);
        wr(8'hB8, 8'h10);
        @(negedge clk); tmr0_ovf = 1'b1;
        @(negedge clk); tmr0_ovf = 1'b0;
        tick(1);
        check("R8 low irq", 16'(irq), 16'h1);
        check("R8 low vector", irq_vec, 16'h000B);
        check("R7 low level", 16'(irq_hp), 16'h0);
        pulse_ack();
        tmr2_req = 1'b1;
        tick(3);
        check("R8 low blocks low", 16'(irq), 16'h0);
        ser_req = 1'b1;
        tick(2);
        check("R8 preempt", 16'(irq), 16'h1);
        check("R8 preempt vector", irq_vec, 16'h0023);
        check("R7 high level", 16'(irq_hp), 16'h1);
        pulse_ack();
        tick(3);
        check("R8 high not preempted", 16'(irq), 16'h0);
        pulse_reti();
        tick(1);
        check("R9 R10 serial again", 16'(irq), 16'h1);
        check("R9 serial vector", irq_vec, 16'h0023);
        ser_req = 1'b0;
        tick(2);
        check("R9 low still in service", 16'(irq), 16'h0);
        pulse_reti();
        tick(1);
        check("R9 low released", 16'(irq), 16'h1);
        check("R9 timer2 vector", irq_vec, 16'h002B);
        tmr2_req = 1'b0;
        tick(2);

        // R6 R7 sweep of all pending patterns under several priority masks
        wr(8'hA8, 8'hBF);
        for (int m = 0; m < 4; m++) begin
            logic [7:0] pm;
            pm = pri_sets[m];
            wr(8'hB8, {2'b00, pm[5:0]});
            for (int p = 0; p < 256; p++) begin
                logic [7:0] pv, hpv;
                int idx;
                pv = 8'(p);
                wr(8'h88, 8'h05 | {2'b00, pv[3], pv[1], pv[2], 1'b0, pv[0], 1'b0});
                wr(8'hC0, 8'h55 | {pm[7], 1'b0, pv[7], 1'b0, pm[6], 1'b0, pv[6], 1'b0});
                ser_req  = pv[4];
                tmr2_req = pv[5];
                tick(2);
                hpv = pv & pm;
                idx = (hpv != 0) ? low_idx(hpv) : low_idx(pv);
                check("R6 sweep irq", 16'(irq), 16'(pv != 0));
                if (pv != 0) begin
                    check("R6 R7 sweep vector", irq_vec, 16'(3 + 8 * idx));
                    check("R7 sweep level", 16'(irq_hp), 16'(hpv != 0));
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule